// File: doc/BRIEF.md
# Collision Backoff Delay Timer

After a collision and jam, a transmitter has to wait a random whole number of slot times before it tries again. This block picks that number and times it. A start pulse carries the number of the coming retransmission. The block draws a pseudo-random slot count from a free-running shift register and masks it to a range that doubles with each retry, up to a cap. It then counts slots on a qualified bit-time tick and raises a one-cycle done pulse when the wait has run out.

A single control input turns on a busy-network mode. In this mode the tick is ignored for as long as receive carrier is sensed. The backoff therefore stretches while the medium is in use, and other stations get the channel first. A new start pulse during a wait discards the old wait and draws a fresh count. The slot length, given in ticks, is a parameter so that short slots can be used in simulation.

Top module: `backoff_timer`

## Requirements
- R1: On a start pulse the slot count r is the low k bits of the shift register as it stands at that clock edge, with k = min(attempt_n, K_MAX) (default K_MAX = 10). An attempt number of 0 gives k = 0.
- R2: The shift register is 16 bits wide and loads 16'hACE1 in reset. On every clock edge after reset it shifts left by one, and bit 0 takes the XOR of the old bits 15, 13, 12 and 10.
- R3: With r > 0, busy is high from the edge after start until done. Done is high in the cycle that follows the edge at which the (r × SLOT_TICKS)-th counted tick is sampled.
- R4: With r = 0, done is high in the cycle right after the start edge, and busy stays low.
- R5: When pause_en is 1, a tick sampled while crs is 1 is not counted.
- R6: When pause_en is 0, crs has no effect on counting.
- R7: A start pulse while busy draws a new r under R1 and restarts both the slot count and the tick count.
- R8: Done lasts exactly one cycle unless another start with r = 0 follows, and done is never high together with busy.
- R9: After reset, done and busy are low.
- R10: A tick sampled on the start edge, or while idle, is not counted and causes no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a backoff |
| attempt_n | input | N_W | Retransmission number n |
| bit_tick | input | 1 | One pulse per bit time |
| crs | input | 1 | Receive carrier sense |
| pause_en | input | 1 | 1 = freeze counting while carrier is sensed |
| busy | output | 1 | A backoff wait is in progress |
| done | output | 1 | One-cycle pulse when the wait ends |

## Verification
Done and busy are both registered. Done therefore appears in the cycle after the clock edge that samples the final counted tick, or in the cycle after the start edge when r is zero. Busy rises in the cycle after start. The bench drives every input on the falling edge and keeps a running count of the ticks that should be counted. After each rising edge it compares done and busy, on the following falling edge, against whether that count has reached r times the slot length. The bench advances its own model of the shift register on the same edges, so the r it expects is the value present at the start edge.

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int SLOT_TICKS = 512,
  parameter int N_W        = 5,
  parameter int K_MAX      = 10,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] attempt_n,
  input  logic           bit_tick,
  input  logic           crs,
  input  logic           pause_en,
  output logic           busy,
  output logic           done
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int KW = $clog2(K_MAX + 1);
  localparam int RW = K_MAX;

  logic [15:0]   lfsr;
  logic [KW-1:0] k;
  logic [RW:0]   one_k;
  logic [RW-1:0] mask, draw, slots;
  logic [TW-1:0] tick_cnt;
  logic          step, slot_end;

  assign k     = (attempt_n > N_W'(K_MAX)) ? KW'(K_MAX) : attempt_n[KW-1:0];
  assign one_k = (RW+1)'(1) << k;
  assign mask  = one_k[RW-1:0] - RW'(1);
  assign draw  = lfsr[RW-1:0] & mask;

  assign step     = busy & bit_tick & ~(pause_en & crs);
  assign slot_end = step & (tick_cnt == TW'(SLOT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      slots    <= '0;
      tick_cnt <= '0;
    end else if (start) begin
      busy     <= (draw != '0);
      done     <= (draw == '0);
      slots    <= draw;
      tick_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (slot_end) begin
        tick_cnt <= '0;
        slots    <= slots - RW'(1);
        if (slots == RW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (step) begin
        tick_cnt <= tick_cnt + TW'(1);
      end
    end
  end
endmodule

module backoff_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bit_tick,
  input logic crs,
  input logic pause_en,
  input logic busy,
  input logic done
);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && pause_en && crs) |=> (!done && busy));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!done && !busy));
  a_r3_no_tick_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !bit_tick) |=> busy);
endmodule

bind backoff_timer backoff_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
  .crs(crs), .pause_en(pause_en), .busy(busy), .done(done)
);

// File: tb/sim_backoff_timer.sv
module sim_backoff_timer;
  localparam int S = 4;
  logic clk = 0, rst_n = 0, start = 0, bit_tick = 0, crs = 0, pause_en = 0;
  logic [4:0] attempt_n = '0;
  logic busy, done;
  logic [15:0] m_lfsr;
  int tests = 0, fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  backoff_timer #(.SLOT_TICKS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .attempt_n(attempt_n),
    .bit_tick(bit_tick), .crs(crs), .pause_en(pause_en),
    .busy(busy), .done(done));

  // R2 model: left shift, feedback bits 15,13,12,10, seed ACE1
  always @(posedge clk) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    cyc <= cyc + 1;
  end

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int draw_r(input int n);
    int k = (n > 10) ? 10 : n;
    return int'(m_lfsr[9:0]) & ((1 << k) - 1);
  endfunction

  // mode 0: tick every cycle, crs low; 1: sparse tick, bursty crs; 2: tick every cycle, crs alternating
  task automatic drive(input int mode, input int c);
    case (mode)
      0: begin bit_tick = 1; crs = 0; end
      1: begin bit_tick = (c % 3) != 2; crs = (c % 7) < 3; end
      default: begin bit_tick = 1; crs = c[0]; end
    endcase
  endtask

  // R1 R3 R4 R5 R6 R7: run one backoff; optional restart after cut cycles
  task automatic go(input int n, input int mode, input bit pe, input int cut);
    int target, eff, c;
    bit restarted = 0;
    pause_en = pe;
    attempt_n = 5'(n);
    target = draw_r(n) * S;
    start = 1; bit_tick = 1; crs = 0;
    @(posedge clk); @(negedge clk);
    start = 0;
    eff = 0; c = 0;
    forever begin
      chk(done == (eff == target), (target == 0) ? "R4 done" : "R3 done", done, eff == target);
      chk(busy == (eff < target), (target == 0) ? "R4 busy" : "R3 busy", busy, eff < target);
      if (eff == target) break;
      if (cut != 0 && c == cut && !restarted) begin
        restarted = 1;
        target = draw_r(n) * S;   // R7 fresh draw
        start = 1; bit_tick = 1; crs = 0;
        @(posedge clk); @(negedge clk);
        start = 0; eff = 0; c++;
        continue;
      end
      drive(mode, c);
      @(posedge clk);
      if (bit_tick && !(pe && crs)) eff++;
      @(negedge clk);
      c++;
    end
    bit_tick = 0; crs = 0;
    @(posedge clk); @(negedge clk);
    chk(done == 0, "R8 pulse", done, 0);
    chk(busy == 0, "R8 idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R9 done", done, 0);
    chk(busy == 0, "R9 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    // R10: idle ticks do nothing
    for (int i = 0; i < 10; i++) begin
      bit_tick = 1; crs = i[0];
      @(posedge clk); @(negedge clk);
      chk(done == 0 && busy == 0, "R10 idle", {busy, done}, 0);
    end
    bit_tick = 0;
    for (int n = 0; n < 16; n++) go(n, 0, 0, 0);       // R1 R3 R4 sweep
    for (int n = 0; n < 13; n++) go(n, 1, 1, 0);       // R5
    for (int n = 0; n < 13; n++) go(n, 1, 0, 0);       // R6
    for (int n = 1; n < 12; n++) go(n, 2, 1, 0);       // R5 alternating carrier
    go(20, 0, 0, 0);                                    // R1 cap at k=10
    go(31, 2, 0, 0);
    for (int n = 2; n < 12; n++) go(n, 0, 0, 3);       // R7 reload
    for (int n = 4; n < 10; n++) go(n, 1, 1, 5);       // R7 with pause
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule